// File: doc/BRIEF.md
# Command Queue Instruction Executor

This block runs a short program of 64-bit commands held in a local instruction store. A host loads the store through a simple write port while the block is idle, then pulses `start`. The executor fetches slot zero and works through the program one command at a time. Each command is a register write, a write-mask setup, a relative jump, an event wait or clear, or an end marker that finishes the run and can raise an interrupt.

Register writes leave through a one-cycle write strobe. It carries a 24-bit target address made of an 8-bit subsystem and a 16-bit offset, together with the data and the bit mask the target must apply. The target merges them as `new = (old & ~mask) | (data & mask)`. Event commands reach an external event table through a request/grant handshake. The request stays up, with its event number and flags held steady, until the table grants it. This handshake is how the program stalls until a hardware event occurs. An opcode outside the command set halts the run and leaves an error flag set until the next start.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `err`, `wr_en` and `ev_req` are all low, and they stay low until `start` is pulsed.
- R2: A `start` pulse while idle begins execution at byte address 0 (slot 0). A `start` that arrives while `busy` is high, including the cycle in which `done` pulses, is ignored.
- R3: A write command has opcode 0x04 in bits 63:56, subsystem in bits 55:48, offset in bits 47:32 and value in bits 31:0. It produces one `wr_en` cycle with `wr_addr` = {subsystem, offset}, `wr_data` = value and `wr_mask` = the current mask.
- R4: A mask command has opcode 0x02 and the mask in bits 31:0. Its mask applies to the next write only. After any write, and after reset or start, the mask is all ones.
- R5: Every command other than a jump advances the program counter by 8 bytes, so commands execute in slot order.
- R6: A jump command has opcode 0x10 and a signed byte offset in bits 31:0, and it adds that offset to the program counter. An offset of 8 goes to the next slot, and a negative offset goes backwards.
- R7: A wait command has opcode 0x20, the event number in bits 41:32, the update flag in bit 31 and the wait flag in bit 15. With the wait flag set, it raises `ev_req` with `ev_wait`=1 and `ev_clr` equal to the update flag. It holds the request, and stalls, until `ev_gnt`. A grant in the first request cycle costs no extra cycle.
- R8: A wait command with the update flag set and the wait flag clear issues a clear-only request (`ev_clr`=1, `ev_wait`=0).
- R9: An end command has opcode 0x40. It pulses `done` for one cycle, pulses `irq` in the same cycle only when bit 0 is set, and then drops `busy`.
- R10: Any other opcode stops execution without `done`. `err` rises and stays high until the next `start`, and that `start` clears it.
- R11: `ev_id` carries the full 10-bit event number, so event 0x3FF is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at slot 0 when idle |
| ld_en | input | 1 | Instruction store write strobe |
| ld_idx | input | IDX_W | Instruction slot to load |
| ld_inst | input | 64 | Instruction to load |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle pulse at end command |
| irq | output | 1 | Interrupt pulse when the end command requests it |
| err | output | 1 | Unknown opcode seen; held until next start |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 24 | Write target {subsystem, offset} |
| wr_data | output | 32 | Write value |
| wr_mask | output | 32 | Bits of the target to update |
| ev_req | output | 1 | Event request |
| ev_id | output | 10 | Event number |
| ev_wait | output | 1 | Request waits for the event |
| ev_clr | output | 1 | Request clears the event |
| ev_gnt | input | 1 | Event table grant |

## Verification
Two pairs of actions can land in one cycle. The first is an event request and its grant: the bench's event table model grants in the first request cycle when the event is already pending, and it withholds the grant for many cycles when it is not. The bench judges both cases by the order of the writes that follow and by the requests it logs. The second is the end-of-command pulse and a fresh `start`: the bench raises `start` in the very cycle `done` is seen. It then expects `busy` to fall and no further writes to appear.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int INST_W = 64;
    localparam int DATA_W = 32;
    localparam int EV_W   = 10;
    localparam int WA_W   = 24;

    localparam logic [7:0] OPC_MASK  = 8'h02;
    localparam logic [7:0] OPC_WRITE = 8'h04;
    localparam logic [7:0] OPC_JUMP  = 8'h10;
    localparam logic [7:0] OPC_WFE   = 8'h20;
    localparam logic [7:0] OPC_EOC   = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_EVWAIT
    } exec_state_e;

    typedef struct packed {
        logic              is_mask;
        logic              is_write;
        logic              is_jump;
        logic              is_wfe;
        logic              is_eoc;
        logic              is_bad;
        logic [WA_W-1:0]   target;
        logic [DATA_W-1:0] arg;
        logic [EV_W-1:0]   ev_num;
        logic              ev_upd;
        logic              ev_wt;
        logic              irq_flag;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [INST_W-1:0] word);
        cmd_t c;
        c          = '0;
        c.target   = word[55:32];
        c.arg      = word[31:0];
        c.ev_num   = word[32+EV_W-1:32];
        c.ev_upd   = word[31];
        c.ev_wt    = word[15];
        c.irq_flag = word[0];
        unique case (word[63:56])
            OPC_MASK:  c.is_mask  = 1'b1;
            OPC_WRITE: c.is_write = 1'b1;
            OPC_JUMP:  c.is_jump  = 1'b1;
            OPC_WFE:   c.is_wfe   = 1'b1;
            OPC_EOC:   c.is_eoc   = 1'b1;
            default:   c.is_bad   = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cmdq_imem.sv
module cmdq_imem #(
    parameter int DEPTH = 16,
    parameter int W     = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_word,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_word
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (rd_en) begin
            rd_word <= store[rd_idx];
        end
    end
endmodule

// File: rtl/cmdq_mask_reg.sv
module cmdq_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         set_en,
    input  logic [W-1:0] set_val,
    input  logic         consume,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst || init || consume) begin
            mask <= '1;
        end else if (set_en) begin
            mask <= set_val;
        end
    end

    // R4: a write always leaves the mask fully open for the next one
    a_r4_mask_reopens: assert property (@(posedge clk) disable iff (rst)
        consume && !set_en |=> mask == '1);
endmodule

// File: rtl/cmdq_pc.sv
module cmdq_pc #(
    parameter int PC_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            adv,
    input  logic            jump,
    input  logic [PC_W-1:0] offs,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(8);

    logic [PC_W-1:0] pc_n;

    always_comb begin
        pc_n = pc;
        if (clear) begin
            pc_n = '0;
        end else if (adv) begin
            pc_n = jump ? pc + offs : pc + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_n;
        end
    end
endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
    import cmdq_pkg::*;
#(
    parameter int IMEM_DEPTH = 16,
    localparam int IDX_W     = $clog2(IMEM_DEPTH),
    localparam int PC_W      = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [INST_W-1:0] ld_inst,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              err,
    output logic              wr_en,
    output logic [WA_W-1:0]   wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wr_mask,
    output logic              ev_req,
    output logic [EV_W-1:0]   ev_id,
    output logic              ev_wait,
    output logic              ev_clr,
    input  logic              ev_gnt
);
    exec_state_e       state_q, state_n;
    logic              err_q;
    logic [INST_W-1:0] inst;
    cmd_t              cmd;
    logic [PC_W-1:0]   pc;
    logic              in_exec, launch, ev_active, ev_done, adv;

    assign in_exec   = (state_q == ST_EXEC);
    assign launch    = (state_q == ST_IDLE) && start;
    assign cmd       = decode_cmd(inst);
    assign ev_active = cmd.is_wfe && (cmd.ev_upd || cmd.ev_wt);

    cmdq_imem #(.DEPTH(IMEM_DEPTH), .W(INST_W)) u_imem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_en),
        .wr_idx  (ld_idx),
        .wr_word (ld_inst),
        .rd_en   (state_q == ST_FETCH),
        .rd_idx  (pc[PC_W-1:3]),
        .rd_word (inst)
    );

    cmdq_mask_reg #(.W(DATA_W)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .init    (launch),
        .set_en  (in_exec && cmd.is_mask),
        .set_val (cmd.arg),
        .consume (wr_en),
        .mask    (wr_mask)
    );

    cmdq_pc #(.PC_W(PC_W)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .adv   (adv),
        .jump  (cmd.is_jump),
        .offs  (cmd.arg[PC_W-1:0]),
        .pc    (pc)
    );

    // event handshake: request straight from EXEC, held in EVWAIT
    assign ev_req  = (in_exec && ev_active) || (state_q == ST_EVWAIT);
    assign ev_id   = cmd.ev_num;
    assign ev_wait = cmd.ev_wt;
    assign ev_clr  = cmd.ev_upd;
    assign ev_done = ev_req && ev_gnt;

    assign wr_en   = in_exec && cmd.is_write;
    assign wr_addr = cmd.target;
    assign wr_data = cmd.arg;

    assign done = in_exec && cmd.is_eoc;
    assign irq  = done && cmd.irq_flag;
    assign busy = (state_q != ST_IDLE);
    assign err  = err_q;

    assign adv = ev_done ||
                 (in_exec && (cmd.is_mask || cmd.is_write || cmd.is_jump ||
                              (cmd.is_wfe && !ev_active)));

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_n = ST_FETCH;
            ST_FETCH:  state_n = ST_EXEC;
            ST_EXEC: begin
                if (cmd.is_bad || cmd.is_eoc) begin
                    state_n = ST_IDLE;
                end else if (ev_active && !ev_gnt) begin
                    state_n = ST_EVWAIT;
                end else begin
                    state_n = ST_FETCH;
                end
            end
            ST_EVWAIT: if (ev_gnt) state_n = ST_FETCH;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            if (launch) begin
                err_q <= 1'b0;
            end else if (in_exec && cmd.is_bad) begin
                err_q <= 1'b1;
            end
        end
    end

    // R9: interrupt only alongside done, and the run ends after done
    a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R3: a write, an event request and an end never share a cycle
    a_r3_single_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, ev_req, done}));
    // R7: an ungranted request keeps its event and flags
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        ev_req && !ev_gnt |=> ev_req && $stable(ev_id) && $stable(ev_clr) && $stable(ev_wait));
    // R10: the error flag means stopped, and only start removes it
    a_r10_err_stopped: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);
    // R1: nothing runs without a start
    a_r1_no_spontaneous_run: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> !busy);
endmodule

// File: tb/cmdq_exec_test.sv
module cmdq_exec_test;
    import cmdq_pkg::*;

    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              ld_en = 1'b0;
    logic [IW-1:0]     ld_idx = '0;
    logic [63:0]       ld_inst = '0;
    logic              busy, done, irq, err, wr_en, ev_req, ev_wait, ev_clr;
    logic              ev_gnt = 1'b0;
    logic [23:0]       wr_addr;
    logic [31:0]       wr_data, wr_mask;
    logic [9:0]        ev_id;

    int checks = 0;
    int fails  = 0;
    int wr_seen = 0;
    int ev_hs = 0;
    logic [9:0] last_id;
    logic       last_wait, last_clr;
    logic       ev_flag [1024];
    logic [87:0] exp_q [$];

    always #5 clk = ~clk;

    cmdq_exec #(.IMEM_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .start(start), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_inst(ld_inst), .busy(busy), .done(done), .irq(irq), .err(err),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .ev_req(ev_req), .ev_id(ev_id), .ev_wait(ev_wait), .ev_clr(ev_clr),
        .ev_gnt(ev_gnt)
    );

    function automatic logic [63:0] c_wr(input logic [7:0] s, input logic [15:0] a, input logic [31:0] v);
        return {8'h04, s, a, v};
    endfunction
    function automatic logic [63:0] c_mask(input logic [31:0] m);
        return {8'h02, 24'h0, m};
    endfunction
    function automatic logic [63:0] c_jump(input logic [31:0] off);
        return {8'h10, 24'h0, off};
    endfunction
    function automatic logic [63:0] c_wfe(input logic [9:0] id, input logic upd, input logic wt);
        return {8'h20, 14'h0, id, upd, 15'h0, wt, 14'h0, wt};
    endfunction
    function automatic logic [63:0] c_eoc(input logic f);
        return {8'h40, 24'h0, 31'h0, f};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int idx, input logic [63:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = IW'(idx); ld_inst = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic expect_wr(input logic [7:0] s, input logic [15:0] a,
                             input logic [31:0] v, input logic [31:0] m);
        exp_q.push_back({s, a, v, m});
    endtask

    task automatic go();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic seen, output logic irq_at);
        seen = 1'b0; irq_at = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; irq_at = irq; break; end
        end
    endtask

    // scoreboard monitor: every write strobe pops one expected item
    initial begin
        forever begin
            @(negedge clk);
            if (wr_en) begin
                wr_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {40'h0, wr_addr}, 64'h0);
                end else begin
                    logic [87:0] e;
                    e = exp_q.pop_front();
                    chk({wr_addr, wr_data, wr_mask} == e, "R3/R4 write",
                        {wr_addr, wr_data[31:0]}, e[87:32]);
                    chk(wr_mask == e[31:0], "R4 mask", {32'h0, wr_mask}, {32'h0, e[31:0]});
                end
            end
        end
    end

    // event table model: grant once waiting is satisfied, clear on request
    initial begin
        forever begin
            @(negedge clk);
            ev_gnt = ev_req && (!ev_wait || ev_flag[ev_id]);
            if (ev_req && ev_gnt) begin
                ev_hs++;
                last_id = ev_id; last_wait = ev_wait; last_clr = ev_clr;
                if (ev_clr) ev_flag[ev_id] = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic seen, irq_at;
        int n;
        for (int i = 0; i < 1024; i++) ev_flag[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        repeat (4) @(negedge clk);
        chk({busy, done, irq, err, wr_en, ev_req} == 6'b0, "R1 idle after reset",
            {58'h0, busy, done, irq, err, wr_en, ev_req}, 64'h0);

        // program A: mask, writes, jumps, clear-only, blocking wait, end with irq
        load(0, c_mask(32'h0000FF00));
        load(1, c_wr(8'h12, 16'h0040, 32'hAABBCCDD));
        load(2, c_wr(8'h03, 16'h0010, 32'h11223344));
        load(3, c_jump(32'd16));
        load(4, c_wr(8'h7F, 16'h0000, 32'hDEADDEAD));
        load(5, c_jump(32'd8));
        load(6, c_wfe(10'd5, 1'b1, 1'b0));
        load(7, c_wfe(10'h3FF, 1'b1, 1'b1));
        load(8, c_wr(8'h01, 16'h0004, 32'hCAFEF00D));
        load(9, c_eoc(1'b1));
        ev_flag[5] = 1'b1;
        expect_wr(8'h12, 16'h0040, 32'hAABBCCDD, 32'h0000FF00);
        expect_wr(8'h03, 16'h0010, 32'h11223344, 32'hFFFFFFFF);
        expect_wr(8'h01, 16'h0004, 32'hCAFEF00D, 32'hFFFFFFFF);
        go();
        chk(busy, "R2 busy after start", {63'h0, busy}, 64'h1);
        n = 0;
        while (!(ev_req && ev_id == 10'h3FF) && n < 200) begin @(negedge clk); n++; end
        chk(ev_req && ev_id == 10'h3FF, "R11 full event number", {54'h0, ev_id}, 64'h3FF);
        chk(ev_hs == 1 && last_id == 10'd5 && !last_wait && last_clr, "R8 clear-only request",
            {50'h0, ev_hs[3:0], last_id}, {50'h0, 4'h1, 10'd5});
        chk(!ev_flag[5], "R8 event cleared", {63'h0, ev_flag[5]}, 64'h0);
        // start while busy must not restart
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        chk(ev_req && ev_wait && ev_clr, "R7 stalled request with wait and clear",
            {61'h0, ev_req, ev_wait, ev_clr}, 64'h7);
        chk(wr_seen == 2, "R7 no progress while waiting", 64'(wr_seen), 64'd2);
        @(posedge clk); #1 ev_flag[10'h3FF] = 1'b1;
        wait_done(seen, irq_at);
        chk(seen, "R9 done reached", {63'h0, seen}, 64'h1);
        chk(irq_at, "R9 irq with flag", {63'h0, irq_at}, 64'h1);
        chk(!ev_flag[10'h3FF] && last_clr && last_wait, "R7 wait then clear",
            {63'h0, ev_flag[10'h3FF]}, 64'h0);
        // start coinciding with done is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R9 done is one cycle, busy drops", {62'h0, busy, done}, 64'h0);
        repeat (10) @(negedge clk);
        chk(!busy && wr_seen == 3, "R2 start in done cycle ignored", 64'(wr_seen), 64'd3);
        chk(exp_q.size() == 0, "R5 all writes in slot order", 64'(exp_q.size()), 64'd0);

        // program B: backward jump, wait-only with pending event, end without irq
        load(0, c_jump(32'd24));
        load(1, c_wr(8'h00, 16'h0100, 32'h00000001));
        load(2, c_eoc(1'b0));
        load(3, c_wfe(10'd7, 1'b0, 1'b1));
        load(4, c_wr(8'h22, 16'h0200, 32'h00000002));
        load(5, c_jump(32'hFFFFFFE0));
        ev_flag[7] = 1'b1;
        expect_wr(8'h22, 16'h0200, 32'h00000002, 32'hFFFFFFFF);
        expect_wr(8'h00, 16'h0100, 32'h00000001, 32'hFFFFFFFF);
        n = ev_hs;
        go();
        wait_done(seen, irq_at);
        chk(seen && !irq_at, "R9 done without irq", {62'h0, seen, irq_at}, 64'h2);
        chk(ev_hs == n + 1 && last_wait && !last_clr && ev_flag[7], "R7 wait-only keeps event",
            {61'h0, last_wait, last_clr, ev_flag[7]}, 64'h5);
        chk(exp_q.size() == 0 && wr_seen == 5, "R6 forward and backward jumps", 64'(wr_seen), 64'd5);

        // program C: unknown opcode
        load(0, c_wr(8'h09, 16'h0008, 32'h0000BEEF));
        load(1, {8'h33, 56'h0});
        load(2, c_wr(8'h09, 16'h000C, 32'h0000F00D));
        expect_wr(8'h09, 16'h0008, 32'h0000BEEF, 32'hFFFFFFFF);
        go();
        wait_done(seen, irq_at);
        chk(!seen, "R10 no done on bad opcode", {63'h0, seen}, 64'h0);
        chk(err && !busy, "R10 error held, stopped", {62'h0, err, busy}, 64'h2);
        chk(wr_seen == 6, "R10 nothing after bad opcode", 64'(wr_seen), 64'd6);
        load(1, c_eoc(1'b0));
        expect_wr(8'h09, 16'h0008, 32'h0000BEEF, 32'hFFFFFFFF);
        go();
        chk(!err, "R10 start clears error", {63'h0, err}, 64'h0);
        wait_done(seen, irq_at);
        chk(seen && !err, "R2 restart runs from slot 0", {62'h0, seen, err}, 64'h2);
        chk(exp_q.size() == 0 && wr_seen == 7, "R3 final write count", 64'(wr_seen), 64'd7);

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule